// File: doc/BRIEF.md
# Offset-Based Tick Counter Register

A 64-bit read/write tick register that never loads its underlying counter. A free-running event counter advances by one on every cycle in which the increment strobe is high. A write keeps two things: the difference between the written low 63 bits and the live count, and the written top bit as a separate flag. A read adds the stored difference back to the live count. The register therefore appears to hold the written value and then keep counting from it.

The read value keeps only bits [62:2] of that 63-bit sum. Bits [1:0] always read as zero, and bit 63 is the stored flag. Two select codes map to the same storage, so a write through either one is seen by a read through either one. The other select codes fall outside the register: writes to them are dropped and reads of them return zero. The read port is combinational.

Top module: `tick_offset_reg`

## Requirements
- R1: After reset, the counter, the offset and the flag are zero, so a read through select 0 or select 1 returns 0.
- R2: The counter advances by one on each clock edge at which `inc_i` is high. With no write, a read returns the count in bits [62:2], with bits [1:0] cleared.
- R3: A write (`wr_i` high, `sel_i` of 0 or 1) with `inc_i` low makes the next read return bits [62:2] of `wdata_i` in bits [62:2].
- R4: Bit 63 of a read is the bit 63 last written. The sum never carries into it.
- R5: Bits [1:0] of `rdata_o` are always zero.
- R6: Select codes 0 and 1 share one storage. A write through one is read back identically through the other.
- R7: For select codes 2 and 3, a write changes nothing and a read returns 0.
- R8: A read in the same cycle as a write returns the value from before the write.
- R9: The offset is taken against the count before that cycle's increment. A write with `inc_i` high reads back next cycle as the written value plus one, masked as above.
- R10: The 63-bit sum of count and offset wraps modulo 2^63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inc_i | input | 1 | Count-increment strobe |
| wr_i | input | 1 | Write strobe |
| sel_i | input | 2 | Register select: 0 and 1 are the aliased tick register, 2 and 3 are unmapped |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Combinational read data |

## Verification
The checker tests four things on every cycle:
- The low two read bits are zero.
- Unmapped selects read zero.
- The flag and the low-63 readback follow a write.
- With no write and no increment, the read value holds while the select moves between the two aliased codes.

Only the bench scenarios can show the other behaviours: counting across many increments, the plus-one result of a write combined with an increment, the pre-write value during a write cycle, dropped writes to unmapped selects, and modular wrap of the sum.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_TICK  = 2'd0,
    SEL_STICK = 2'd1,
    SEL_RSV2  = 2'd2,
    SEL_RSV3  = 2'd3
  } tick_sel_e;
endpackage

// File: rtl/tick_cnt.sv
module tick_cnt #(
  parameter int unsigned W = 63
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/tick_ofs_store.sv
module tick_ofs_store #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [W-1:0]      cnt_i,
  output logic [W-1:0]      ofs_o,
  output logic              flag_o
);
  // offset is taken against pre-increment count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_o  <= '0;
      flag_o <= 1'b0;
    end else if (wr_en_i) begin
      ofs_o  <= wdata_i[W-1:0] - cnt_i;
      flag_o <= wdata_i[DATA_W-1];
    end
  end
endmodule

// File: rtl/tick_rd_fmt.sv
module tick_rd_fmt #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LSB_ZERO = 2,
  localparam int unsigned W = DATA_W - 1
) (
  input  logic [W-1:0]      cnt_i,
  input  logic [W-1:0]      ofs_i,
  input  logic              flag_i,
  input  logic              hit_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [W-1:0] sum;
  logic [W-1:0] sum_m;

  assign sum = cnt_i + ofs_i;

  generate
    if (LSB_ZERO > 0) begin : g_mask
      localparam logic [W-1:0] MASK = ~((W'(1) << LSB_ZERO) - W'(1));
      assign sum_m = sum & MASK;
    end else begin : g_nomask
      assign sum_m = sum;
    end
  endgenerate

  assign rdata_o = hit_i ? {flag_i, sum_m} : '0;
endmodule

// File: rtl/tick_offset_reg.sv
module tick_offset_reg
  import tick_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LSB_ZERO = 2,
  localparam int unsigned W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic         hit;
  logic [W-1:0] cnt;
  logic [W-1:0] ofs;
  logic         flag;

  // both tick codes alias one storage
  assign hit = (sel_i == SEL_TICK) || (sel_i == SEL_STICK);

  tick_cnt #(.W(W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc_i),
    .cnt_o (cnt)
  );

  tick_ofs_store #(.DATA_W(DATA_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_i && hit),
    .wdata_i(wdata_i),
    .cnt_i  (cnt),
    .ofs_o  (ofs),
    .flag_o (flag)
  );

  tick_rd_fmt #(.DATA_W(DATA_W), .LSB_ZERO(LSB_ZERO)) i_fmt (
    .cnt_i  (cnt),
    .ofs_i  (ofs),
    .flag_i (flag),
    .hit_i  (hit),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/tick_offset_reg_chk.sv
module tick_offset_reg_chk #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned LSB_ZERO = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inc_i,
  input logic              wr_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o
);
  logic hit;
  assign hit = (sel_i == 2'd0) || (sel_i == 2'd1);

  // R5
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[1:0] == 2'b00);

  // R7
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rdata_o == '0);

  // R4
  flag_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit) |=> (!hit || rdata_o[DATA_W-1] == $past(wdata_i[DATA_W-1])));

  // R3
  wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && !inc_i) |=>
      (!hit || rdata_o[DATA_W-2:LSB_ZERO] == $past(wdata_i[DATA_W-2:LSB_ZERO])));

  // R6
  alias_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wr_i && !inc_i) |=> (!hit || $stable(rdata_o)));
endmodule

bind tick_offset_reg tick_offset_reg_chk #(.DATA_W(DATA_W), .LSB_ZERO(LSB_ZERO)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .inc_i  (inc_i),
  .wr_i   (wr_i),
  .sel_i  (sel_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o)
);

// File: tb/test_tick_offset_reg.sv
module test_tick_offset_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  // bench model
  logic [62:0] m_cnt = '0;
  logic [62:0] m_ofs = '0;
  logic        m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tick_offset_reg i_tick_offset_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .wr_i(wr_i),
    .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic logic [63:0] expect_rd(input logic [1:0] s);
    logic [62:0] sum;
    sum = m_cnt + m_ofs;
    if (s > 2'd1) return 64'd0;
    return {m_flag, sum[62:2], 2'b00};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive, check pre-edge read, update model
  task automatic cyc(input string tag, input logic inc, input logic wr,
                     input logic [1:0] s, input logic [63:0] d);
    inc_i = inc; wr_i = wr; sel_i = s; wdata_i = d;
    #1;
    check(tag, rdata_o, expect_rd(s));
    @(posedge clk_i);
    if (wr && s <= 2'd1) begin
      m_ofs  = d[62:0] - m_cnt;
      m_flag = d[63];
    end
    if (inc) m_cnt = m_cnt + 63'd1;
    @(negedge clk_i);
    inc_i = 1'b0; wr_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    cyc("R1 reset sel0", 1'b0, 1'b0, 2'd0, '0);
    cyc("R1 reset sel1", 1'b0, 1'b0, 2'd1, '0);
    // R2 counting, alternating aliased selects (R6)
    for (int i = 0; i < 40; i++)
      cyc("R2 count", 1'b1, 1'b0, 2'(i % 2), '0);
    // R3 R4 R6: write via 0, read via 1
    cyc("R3 write", 1'b0, 1'b1, 2'd0, 64'h8123_4567_89AB_CDEF);
    cyc("R3 R4 R6 readback", 1'b0, 1'b0, 2'd1, '0);
    check("R3 direct", rdata_o, 64'h8123_4567_89AB_CDEC);
    // R8: during write cycle read returns old value
    inc_i = 1'b0; wr_i = 1'b1; sel_i = 2'd1; wdata_i = 64'h0000_0000_0000_1000; #1;
    check("R8 pre-write", rdata_o, 64'h8123_4567_89AB_CDEC);
    @(posedge clk_i);
    m_ofs = 63'h1000 - m_cnt; m_flag = 1'b0;
    @(negedge clk_i); wr_i = 1'b0;
    cyc("R8 post-write", 1'b0, 1'b0, 2'd0, '0);
    // R9: write with increment
    cyc("R9 write+inc", 1'b1, 1'b1, 2'd0, 64'h0000_0000_0000_0203);
    cyc("R9 readback", 1'b0, 1'b0, 2'd0, '0);
    check("R9 direct", rdata_o, 64'h0000_0000_0000_0204);
    // R7: unmapped writes ignored, reads zero
    cyc("R7 wr sel2", 1'b0, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc("R7 wr sel3", 1'b0, 1'b1, 2'd3, 64'h1234_0000_0000_0000);
    cyc("R7 rd sel2", 1'b0, 1'b0, 2'd2, '0);
    cyc("R7 rd sel3", 1'b0, 1'b0, 2'd3, '0);
    cyc("R7 storage kept", 1'b0, 1'b0, 2'd0, '0);
    check("R7 direct", rdata_o, 64'h0000_0000_0000_0204);
    // R10 wrap of the sum, flag clear
    cyc("R10 write max", 1'b0, 1'b1, 2'd1, 64'h7FFF_FFFF_FFFF_FFFE);
    for (int i = 0; i < 8; i++)
      cyc("R10 wrap", 1'b1, 1'b0, 2'd0, '0);
    cyc("R10 wrapped", 1'b0, 1'b0, 2'd0, '0);
    check("R10 direct", rdata_o, 64'h0000_0000_0000_0004);
    // R4 flag survives wrap
    cyc("R4 write all ones", 1'b0, 1'b1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 3; i++)
      cyc("R4 wrap flag", 1'b1, 1'b0, 2'd1, '0);
    cyc("R4 wrapped", 1'b0, 1'b0, 2'd1, '0);
    check("R4 direct", rdata_o, 64'h8000_0000_0000_0000);
    // R5 R6 R9 sweep over data, selects and increment patterns
    for (int i = 0; i < 64; i++) begin
      cyc("R5 R9 sweep wr", 1'(i % 3 == 0), 1'b1, 2'(i % 4),
          {1'(i % 2), 55'(i * 977), 8'(i)});
      for (int j = 0; j < 5; j++)
        cyc("R5 R6 sweep rd", 1'(j != 2), 1'b0, 2'((i + j) % 4), '0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule